// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Request Controller

This block collects interrupt events from five sources (two external request pins, two timer overflow events and one serial event), latches them as pending flags and selects at most one of them for the CPU core. A global enable and one enable bit per source gate the flags. A priority bit per source places each source in a high or a low level. Within a level a fixed order decides. The winner is presented as a registered request with a 3-bit vector index, which the core consumes with an acknowledge pulse.

Each external pin is active low and can be set for level or falling-edge triggering. The core reports each instruction boundary with a strobe. With that strobe it also flags a return-from-interrupt, or an instruction that wrote the enable or priority settings. Requests are chosen only at a boundary, and never at one where either flag is high, so at least one further instruction always completes first. The block tracks which levels are in service, so that a high-level source can interrupt a low-level handler and nothing else can preempt.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `irq_req` is 0, `irq_vec` is 0 and `svc_level` is 2'b00.
- R2: External input i uses falling-edge mode when `ext_edge_sel[i]`=1. A high-to-low transition on `ext_n[i]` sets its flag, and the flag stays set after the pin returns high. With `ext_edge_sel[i]`=0 the request follows the pin and is pending while `ext_n[i]` is low.
- R3: Acknowledging an edge-mode external vector or a timer vector clears that source's flag.
- R4: A level-mode external request whose pin is still low after the handler returns is selected again at a later boundary.
- R5: The serial flag is set by `ser_evt` and cleared only by `ser_clr`. An acknowledge leaves it set.
- R6: A request is selected only on a cycle with `insn_done`=1. Once raised, `irq_req` and `irq_vec` hold until `irq_ack`.
- R7: A boundary where `insn_is_reti` or `insn_is_cfg_wr` is 1 never raises a request. The next plain boundary may raise one.
- R8: A source takes part only when `glb_en`=1 and its bit in `src_en` is 1.
- R9: Sources with their `src_hi` bit set win over all low-level sources. Within a level the lowest index wins. The vector indices are 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1 and 4 = serial, and bit k of `src_en`, `src_hi` refers to index k.
- R10: `svc_level[1]` marks a high-level handler in service and `svc_level[0]` a low-level one. An acknowledge sets the bit of the taken level. A return clears the high bit if it is set, and otherwise the low bit. A low-level source is selected only when `svc_level` is 2'b00. A high-level source is selected only when `svc_level[1]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_n | input | 2 | External request pins, active low |
| ext_edge_sel | input | 2 | Per-pin trigger select: 1 falling edge, 0 level |
| tmr_ovf | input | 2 | Timer overflow event pulses |
| ser_evt | input | 1 | Serial event pulse, sets the serial flag |
| ser_clr | input | 1 | Software clear of the serial flag |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | 5 | Per-source enables, bit k is vector k |
| src_hi | input | 5 | Per-source high-priority select |
| insn_done | input | 1 | Instruction boundary strobe |
| insn_is_reti | input | 1 | The finishing instruction is a return-from-interrupt |
| insn_is_cfg_wr | input | 1 | The finishing instruction accessed the enable or priority settings |
| irq_ack | input | 1 | Core accepts the presented vector |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 3 | Vector index of the presented request |
| svc_level | output | 2 | Levels currently in service |

## Verification
The assertions assume that `irq_ack` is pulsed only while `irq_req` is high, and only for a single cycle. They also assume that `insn_is_reti` and `insn_is_cfg_wr` are meaningful only together with `insn_done`, and that a return is reported only while some level is in service. The bench drives every input on the falling clock edge. It raises `irq_ack` for one cycle only after it has seen a request. It sends a return strobe only after an acknowledge. Event pulses last one cycle, and flags have several cycles to settle before the next boundary strobe.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_N_EXT = 2;
  localparam int IRQ_N_SRC = 2 * IRQ_N_EXT + 1;
  localparam int IRQ_VEC_W = $clog2(IRQ_N_SRC);
  // service level bits: [1] high level active, [0] low level active
  localparam int SVC_HI = 1;
  localparam int SVC_LO = 0;
endpackage

// File: rtl/irq_src_flags.sv
module irq_src_flags
  import irq_pkg::*;
#(
  parameter int N_EXT = IRQ_N_EXT,
  localparam int N_SRC = 2 * N_EXT + 1,
  localparam int VEC_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_n,
  input  logic [N_EXT-1:0] ext_edge_sel,
  input  logic [N_EXT-1:0] tmr_ovf,
  input  logic             ser_evt,
  input  logic             ser_clr,
  input  logic             ack_fire,
  input  logic [VEC_W-1:0] ack_vec,
  output logic [N_SRC-1:0] flags
);
  localparam int SER_IDX = N_SRC - 1;

  logic [N_EXT-1:0] pin_q, pin_qq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= '1;
      pin_qq <= '1;
    end else begin
      pin_q  <= ext_n;
      pin_qq <= pin_q;
    end
  end

  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    localparam int EI = 2 * i;
    localparam int TI = 2 * i + 1;
    logic fall_w, ack_ext_w, ack_tmr_w;
    logic edge_flag, tmr_flag;

    assign fall_w    = pin_qq[i] & ~pin_q[i];
    assign ack_ext_w = ack_fire && (ack_vec == VEC_W'(EI));
    assign ack_tmr_w = ack_fire && (ack_vec == VEC_W'(TI));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                edge_flag <= 1'b0;
      else if (!ext_edge_sel[i]) edge_flag <= 1'b0;
      else if (fall_w)           edge_flag <= 1'b1;
      else if (ack_ext_w)        edge_flag <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          tmr_flag <= 1'b0;
      else if (tmr_ovf[i]) tmr_flag <= 1'b1;
      else if (ack_tmr_w)  tmr_flag <= 1'b0;
    end

    assign flags[EI] = ext_edge_sel[i] ? edge_flag : ~pin_q[i];
    assign flags[TI] = tmr_flag;

    // R3: acknowledge of a timer vector removes its flag
    p_tmr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_tmr_w && !tmr_ovf[i]) |=> !tmr_flag);
    // R2: an edge flag persists until acknowledged
    p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_flag && ext_edge_sel[i] && !ack_ext_w) |=> (edge_flag || !ext_edge_sel[i]));
  end

  logic ser_flag;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ser_flag <= 1'b0;
    else if (ser_evt) ser_flag <= 1'b1;
    else if (ser_clr) ser_flag <= 1'b0;
  end
  assign flags[SER_IDX] = ser_flag;

  // R5: only the software clear removes the serial flag
  p_ser_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_flag && !ser_clr) |=> ser_flag);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_SRC = IRQ_N_SRC,
  localparam int VEC_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] flags,
  input  logic [N_SRC-1:0] src_en,
  input  logic [N_SRC-1:0] src_hi,
  input  logic             glb_en,
  input  logic [1:0]       svc,
  output logic             cand_valid,
  output logic             cand_hi,
  output logic [VEC_W-1:0] cand_vec
);
  // lowest set index of a mask
  function automatic logic [VEC_W-1:0] first_set(input logic [N_SRC-1:0] m);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (m[k]) r = VEC_W'(k);
    end
    return r;
  endfunction

  logic [N_SRC-1:0] live_w, hi_set_w, lo_set_w;
  logic             hi_ok_w, lo_ok_w, take_hi_w, take_lo_w;

  assign live_w    = flags & src_en & {N_SRC{glb_en}};
  assign hi_set_w  = live_w & src_hi;
  assign lo_set_w  = live_w & ~src_hi;
  assign hi_ok_w   = !svc[SVC_HI];
  assign lo_ok_w   = (svc == 2'b00);
  assign take_hi_w = hi_ok_w && (|hi_set_w);
  assign take_lo_w = lo_ok_w && (|lo_set_w) && !take_hi_w;

  assign cand_valid = take_hi_w || take_lo_w;
  assign cand_hi    = take_hi_w;
  assign cand_vec   = take_hi_w ? first_set(hi_set_w) : first_set(lo_set_w);

  // R8: a disabled controller offers nothing
  always_comb begin
    if (!glb_en) p_gate_r8: assert (!cand_valid);
  end
  // R9: chosen source is enabled and pending
  always_comb begin
    if (cand_valid) p_cand_live_r9: assert (live_w[cand_vec]);
  end
endmodule

// File: rtl/irq_svc_tracker.sv
module irq_svc_tracker
  import irq_pkg::*;
#(
  parameter int N_SRC = IRQ_N_SRC,
  localparam int VEC_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_done,
  input  logic             insn_is_reti,
  input  logic             insn_is_cfg_wr,
  input  logic             irq_ack,
  input  logic             cand_valid,
  input  logic             cand_hi,
  input  logic [VEC_W-1:0] cand_vec,
  output logic             req_q,
  output logic [VEC_W-1:0] vec_q,
  output logic [1:0]       svc_q,
  output logic             ack_fire
);
  logic accept_w, blocked_w, ret_w, lvl_q;
  logic [1:0] svc_nxt;

  assign blocked_w = insn_is_reti | insn_is_cfg_wr;
  assign accept_w  = insn_done && !blocked_w && !req_q && cand_valid;
  assign ack_fire  = irq_ack && req_q;
  assign ret_w     = insn_done && insn_is_reti;

  always_comb begin
    svc_nxt = svc_q;
    if (ret_w) begin
      if (svc_q[SVC_HI]) svc_nxt[SVC_HI] = 1'b0;
      else               svc_nxt[SVC_LO] = 1'b0;
    end
    if (ack_fire) begin
      if (lvl_q) svc_nxt[SVC_HI] = 1'b1;
      else       svc_nxt[SVC_LO] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      vec_q <= '0;
      lvl_q <= 1'b0;
      svc_q <= 2'b00;
    end else begin
      svc_q <= svc_nxt;
      if (accept_w) begin
        req_q <= 1'b1;
        vec_q <= cand_vec;
        lvl_q <= cand_hi;
      end else if (ack_fire) begin
        req_q <= 1'b0;
      end
    end
  end

  // R6: a request appears only after a boundary strobe
  p_strobe_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(insn_done));
  // R6: request and vector hold until acknowledged
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !irq_ack) |=> (req_q && $stable(vec_q)));
  // R7: no acceptance at a return or settings-access boundary
  p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> !($past(insn_is_reti) || $past(insn_is_cfg_wr)));
  // R10: nothing preempts a high-level handler
  p_no_preempt_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> !$past(svc_q[SVC_HI]));
  // R10: a low-level request only when idle
  p_lo_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_q) && !lvl_q) |-> ($past(svc_q) == 2'b00));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int N_EXT = IRQ_N_EXT,
  localparam int N_SRC = 2 * N_EXT + 1,
  localparam int VEC_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_n,
  input  logic [N_EXT-1:0] ext_edge_sel,
  input  logic [N_EXT-1:0] tmr_ovf,
  input  logic             ser_evt,
  input  logic             ser_clr,
  input  logic             glb_en,
  input  logic [N_SRC-1:0] src_en,
  input  logic [N_SRC-1:0] src_hi,
  input  logic             insn_done,
  input  logic             insn_is_reti,
  input  logic             insn_is_cfg_wr,
  input  logic             irq_ack,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic [1:0]       svc_level
);
  logic [N_SRC-1:0] flags_w;
  logic             cand_valid_w, cand_hi_w, ack_fire_w;
  logic [VEC_W-1:0] cand_vec_w;

  irq_src_flags #(.N_EXT(N_EXT)) u_flags (
    .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .ext_edge_sel(ext_edge_sel),
    .tmr_ovf(tmr_ovf), .ser_evt(ser_evt), .ser_clr(ser_clr),
    .ack_fire(ack_fire_w), .ack_vec(irq_vec), .flags(flags_w)
  );

  irq_arbiter #(.N_SRC(N_SRC)) u_arb (
    .flags(flags_w), .src_en(src_en), .src_hi(src_hi), .glb_en(glb_en),
    .svc(svc_level), .cand_valid(cand_valid_w), .cand_hi(cand_hi_w),
    .cand_vec(cand_vec_w)
  );

  irq_svc_tracker #(.N_SRC(N_SRC)) u_svc (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done),
    .insn_is_reti(insn_is_reti), .insn_is_cfg_wr(insn_is_cfg_wr),
    .irq_ack(irq_ack), .cand_valid(cand_valid_w), .cand_hi(cand_hi_w),
    .cand_vec(cand_vec_w), .req_q(irq_req), .vec_q(irq_vec),
    .svc_q(svc_level), .ack_fire(ack_fire_w)
  );

  // R1: quiet right after reset release
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_req && svc_level == 2'b00));
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ext_n = 2'b11, ext_edge_sel = 2'b00, tmr_ovf = 2'b00;
  logic ser_evt = 0, ser_clr = 0, glb_en = 0;
  logic [4:0] src_en = '0, src_hi = '0;
  logic insn_done = 0, insn_is_reti = 0, insn_is_cfg_wr = 0, irq_ack = 0;
  logic irq_req;
  logic [2:0] irq_vec;
  logic [1:0] svc_level;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .ext_edge_sel(ext_edge_sel),
    .tmr_ovf(tmr_ovf), .ser_evt(ser_evt), .ser_clr(ser_clr), .glb_en(glb_en),
    .src_en(src_en), .src_hi(src_hi), .insn_done(insn_done),
    .insn_is_reti(insn_is_reti), .insn_is_cfg_wr(insn_is_cfg_wr),
    .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec),
    .svc_level(svc_level)
  );

  // {glb, en[4:0], hi[4:0], raise[4:0], exp_req, exp_vec[2:0]}
  localparam logic [19:0] VT [10] = '{
    {1'b1, 5'b11111, 5'b00000, 5'b11111, 1'b1, 3'd0},
    {1'b1, 5'b11110, 5'b00000, 5'b11111, 1'b1, 3'd1},
    {1'b1, 5'b11111, 5'b10000, 5'b11111, 1'b1, 3'd4},
    {1'b1, 5'b11111, 5'b01000, 5'b00101, 1'b1, 3'd0},
    {1'b1, 5'b00000, 5'b00000, 5'b11111, 1'b0, 3'd0},
    {1'b0, 5'b11111, 5'b00000, 5'b11111, 1'b0, 3'd0},
    {1'b1, 5'b11111, 5'b01010, 5'b11111, 1'b1, 3'd1},
    {1'b1, 5'b10100, 5'b00000, 5'b10100, 1'b1, 3'd2},
    {1'b1, 5'b11111, 5'b00000, 5'b10000, 1'b1, 3'd4},
    {1'b1, 5'b11111, 5'b00100, 5'b01011, 1'b1, 3'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ext_n = 2'b11; ext_edge_sel = 2'b00; tmr_ovf = 0;
    ser_evt = 0; ser_clr = 0; glb_en = 1; src_en = 5'b11111; src_hi = 0;
    step(2);
    rst_n = 1;
    step(1);
  endtask

  task automatic strobe(input logic reti, input logic cfg);
    insn_done = 1; insn_is_reti = reti; insn_is_cfg_wr = cfg;
    step(1);
    insn_done = 0; insn_is_reti = 0; insn_is_cfg_wr = 0;
  endtask

  task automatic ack();
    irq_ack = 1;
    step(1);
    irq_ack = 0;
  endtask

  task automatic raise(input logic [4:0] m);
    if (m[0]) ext_n[0] = 0;
    if (m[2]) ext_n[1] = 0;
    tmr_ovf = {m[3], m[1]};
    ser_evt = m[4];
    step(1);
    tmr_ovf = 0; ser_evt = 0;
    step(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 req", int'(irq_req), 0);
    chk("R1 vec", int'(irq_vec), 0);
    chk("R1 svc", int'(svc_level), 0);

    // table: gating and ordering (R8, R9)
    for (int v = 0; v < 10; v++) begin
      do_reset();
      glb_en = VT[v][19]; src_en = VT[v][18:14]; src_hi = VT[v][13:9];
      raise(VT[v][8:4]);
      strobe(0, 0);
      chk($sformatf("R8/R9 vector %0d req", v), int'(irq_req), int'(VT[v][3]));
      if (VT[v][3]) chk($sformatf("R9 vector %0d vec", v), int'(irq_vec), int'(VT[v][2:0]));
    end

    // R6: no strobe, no request; then hold until ack
    do_reset();
    raise(5'b10000);
    step(4);
    chk("R6 no strobe", int'(irq_req), 0);
    strobe(0, 0);
    chk("R6 req", int'(irq_req), 1);
    step(4);
    chk("R6 hold req", int'(irq_req), 1);
    chk("R6 hold vec", int'(irq_vec), 4);
    ack();
    chk("R6 ack drops req", int'(irq_req), 0);
    // R5: serial flag survives acknowledge
    strobe(1, 0);
    strobe(0, 0);
    chk("R5 serial again", int'(irq_req), 1);
    chk("R5 serial vec", int'(irq_vec), 4);
    ack();
    ser_clr = 1; step(1); ser_clr = 0;
    strobe(1, 0);
    strobe(0, 0);
    chk("R5 cleared by software", int'(irq_req), 0);

    // R7: settings-access boundary blocks, next plain one accepts
    do_reset();
    raise(5'b01000);
    strobe(0, 1);
    chk("R7 cfg blocked", int'(irq_req), 0);
    strobe(0, 0);
    chk("R7 next accepts", int'(irq_req), 1);
    chk("R7 vec", int'(irq_vec), 3);

    // R2/R3: falling edge latched, cleared by ack
    do_reset();
    ext_edge_sel = 2'b01;
    ext_n[0] = 0; step(1); ext_n[0] = 1; step(3);
    strobe(0, 0);
    chk("R2 edge latched", int'(irq_req), 1);
    chk("R2 edge vec", int'(irq_vec), 0);
    ack();
    chk("R10 low svc", int'(svc_level), 1);
    strobe(1, 0);
    chk("R7 reti blocked", int'(irq_req), 0);
    chk("R10 reti clears", int'(svc_level), 0);
    strobe(0, 0);
    chk("R3 edge flag cleared", int'(irq_req), 0);

    // R3: timer flag cleared by ack
    do_reset();
    raise(5'b00010);
    strobe(0, 0);
    ack();
    strobe(1, 0);
    strobe(0, 0);
    chk("R3 timer flag cleared", int'(irq_req), 0);

    // R4: held level request is taken again
    do_reset();
    ext_n[1] = 0; step(3);
    strobe(0, 0);
    chk("R2 level vec", int'(irq_vec), 2);
    ack();
    strobe(1, 0);
    strobe(0, 0);
    chk("R4 retaken", int'(irq_req), 1);
    chk("R4 vec", int'(irq_vec), 2);

    // R10: preemption rules
    do_reset();
    src_hi = 5'b00100;
    raise(5'b00010);
    strobe(0, 0);
    chk("R10 low taken", int'(irq_vec), 1);
    ack();
    raise(5'b01000);
    strobe(0, 0);
    chk("R10 low cannot preempt low", int'(irq_req), 0);
    ext_n[1] = 0; step(3);
    strobe(0, 0);
    chk("R10 high preempts", int'(irq_req), 1);
    chk("R10 high vec", int'(irq_vec), 2);
    ack();
    chk("R10 both levels", int'(svc_level), 3);
    src_hi = 5'b00101; ext_n[0] = 0; step(3);
    strobe(0, 0);
    chk("R10 high cannot preempt high", int'(irq_req), 0);
    strobe(1, 0);
    chk("R10 reti clears high first", int'(svc_level), 1);
    strobe(0, 0);
    chk("R9 high order", int'(irq_vec), 0);
    chk("R10 high over low handler", int'(irq_req), 1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule